// File: doc/BRIEF.md
# Triggered Sample Capture Core

This block is the acquisition engine of a small logic analyzer. It takes a parallel channel word, samples it on a strobe, and stores the samples in on-chip memory. The strobe comes from one of two places: an internal divider that cuts time into equal slices, or the rising edge of an external qualifier clock that is synchronized inside the block. A single-stage trigger compares the masked channels against a reference value. The reference can be applied inverted, so that active-low buses match on their asserted level.

After an arm command the core writes every sample into a circular buffer. Software picks how many samples to keep from before the trigger. When the trigger fires, the core fills the rest of the memory, stops by itself and raises a done flag. If the trigger is disabled, capture starts at arm and stops when the memory is full. The memory can hold the full channel word, or only the low eight channels with four times the depth. The stored window is streamed out oldest-first through a valid/ready port. The sink may hold off `out_ready` for any number of cycles. While it does, `out_data` and `out_last` stay frozen and no word is lost or repeated.

Top module: `la_capture_core`

## Requirements
- R1: After reset, `busy`, `done` and `out_valid` are 0.
- R2: With the trigger disabled (mode bit 0 = 0), capture starts at `arm` and stops after exactly as many samples as the memory depth. `cap_len` then equals the depth and `trig_pos` is 0.
- R3: The trigger fires on the first sample where every channel whose mask bit (register 0) is set equals the matching bit of the value (register 1). Channels whose mask bit is clear have no effect.
- R4: With mode bit 1 set, the bitwise complement of register 1 is used as the trigger value.
- R5: The pre-trigger count is taken from mode bits 31:16 and clamped to depth-1. The window is that many samples before the trigger sample, followed by depth-minus-pre samples starting with the trigger sample. `trig_pos` gives the readout index of the trigger sample, and `cap_len` equals the depth.
- R6: If the trigger fires before the pre-trigger count has been reached, only the samples actually held are kept before it. `trig_pos` and `cap_len` shrink to match.
- R7: `done` rises after the sample that completes the window, not earlier, and `busy` falls at the same time.
- R8: With mode bit 3 set, exactly one sample is taken per rising edge of `ext_clk`.
- R9: With mode bit 3 clear, one sample is taken every D+1 clock cycles, where D is mode bits 15:4.
- R10: With mode bit 2 set, only channels 7:0 are stored and the depth is four times the wide depth. Readout words carry the stored byte in bits 7:0 and zeros above it.
- R11: After `rd_start` in the done state, the window is streamed oldest-first, one word per `out_valid && out_ready` cycle, with `out_last` on the final word only. The word is held stable while `out_ready` is low.
- R12: `arm` clears `done` on the next cycle. Configuration written after `arm` does not affect the capture in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 mask, 1 value, 2 mode |
| cfg_wdata | input | 32 | Configuration write data |
| arm | input | 1 | Start a new capture (single-cycle pulse) |
| chan_in | input | CH_W | Channel inputs |
| ext_clk | input | 1 | External sample qualifier, asynchronous |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Window complete and ready for readout |
| cap_len | output | AW+3 | Number of words in the stored window |
| trig_pos | output | AW+2 | Readout index of the trigger sample |
| rd_start | input | 1 | Begin streaming the window |
| out_valid | output | 1 | Readout word valid |
| out_ready | input | 1 | Sink accepts the readout word |
| out_data | output | CH_W | Readout word |
| out_last | output | 1 | Final word of the window |

## Verification
An external qualifier edge becomes a stored sample about four cycles later: two synchronizer stages, an edge stage, a sample register and the write. For that reason the bench holds the channel word steady for several cycles around every edge and reads `done` only after the pulse has ended, at which point the completing sample is certainly written. `done` and `busy` change one cycle after the last write, and `arm` clears `done` by the next negative edge. Readout has one fetch cycle between accepted words, so the bench sets `out_ready` at the negative edge and accepts a word only when it sees `out_valid` with its own ready. This puts every comparison at a fixed point, independent of how wide the bubbles are.

// File: rtl/la_pkg.sv
package la_pkg;
  localparam int CFG_W  = 32;
  localparam int DIV_W  = 12;
  localparam int PRE_W  = 16;

  localparam logic [1:0] REG_MASK  = 2'd0;
  localparam logic [1:0] REG_VALUE = 2'd1;
  localparam logic [1:0] REG_MODE  = 2'd2;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [DIV_W-1:0] div;
    logic             ext_sel;
    logic             narrow;
    logic             invert;
    logic             trig_en;
  } mode_t;

  typedef enum logic [1:0] {CAP_IDLE, CAP_PRE, CAP_POST, CAP_DONE} cap_state_t;
  typedef enum logic [1:0] {RD_IDLE, RD_FETCH, RD_SHOW} rd_state_t;
endpackage

// File: rtl/la_strobe.sv
module la_strobe #(
  parameter int CH_W  = 32,
  parameter int DIV_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ext_sel,
  input  logic [DIV_W-1:0] div,
  input  logic            ext_clk,
  input  logic [CH_W-1:0] chan_in,
  output logic            strobe,
  output logic [CH_W-1:0] chan_out
);
  logic             ext_s1, ext_s2, ext_s3;
  logic [CH_W-1:0]  chan_d1, chan_d2;
  logic [DIV_W-1:0] cnt;

  // channel delay matches the qualifier synchronizer depth
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_s1  <= 1'b0;
      ext_s2  <= 1'b0;
      ext_s3  <= 1'b0;
      chan_d1 <= '0;
      chan_d2 <= '0;
    end else begin
      ext_s1  <= ext_clk;
      ext_s2  <= ext_s1;
      ext_s3  <= ext_s2;
      chan_d1 <= chan_in;
      chan_d2 <= chan_d1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!run || ext_sel)     cnt <= '0;
    else if (cnt == div)          cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  assign strobe   = run && (ext_sel ? (ext_s2 && !ext_s3) : (cnt == div));
  assign chan_out = chan_d2;
endmodule

// File: rtl/la_trig_match.sv
module la_trig_match #(
  parameter int CH_W = 32
) (
  input  logic [CH_W-1:0] sample,
  input  logic [CH_W-1:0] mask,
  input  logic [CH_W-1:0] value,
  output logic            hit
);
  assign hit = ~|((sample ^ value) & mask);
endmodule

// File: rtl/la_sample_ram.sv
module la_sample_ram #(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  narrow,
  input  logic                  we,
  input  logic [AW+$clog2(LANES)-1:0] wr_idx,
  input  logic [8*LANES-1:0]    wr_data,
  input  logic [AW+$clog2(LANES)-1:0] rd_idx,
  output logic [8*LANES-1:0]    rd_data
);
  localparam int LANE_AW = $clog2(LANES);
  localparam int PW      = AW + LANE_AW;
  localparam int DEPTH   = 1 << AW;
  localparam int DW      = 8 * LANES;

  logic [DW-1:0]      lane_q;
  logic [LANE_AW-1:0] rd_lane_q;
  logic               narrow_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0]    mem [DEPTH];
    logic [7:0]    q;
    logic          sel_w;
    logic [AW-1:0] wa, ra;
    logic [7:0]    wd;

    assign sel_w = narrow ? (wr_idx[LANE_AW-1:0] == LANE_AW'(g)) : 1'b1;
    assign wa    = narrow ? wr_idx[PW-1:LANE_AW] : wr_idx[AW-1:0];
    assign ra    = narrow ? rd_idx[PW-1:LANE_AW] : rd_idx[AW-1:0];
    assign wd    = narrow ? wr_data[7:0] : wr_data[8*g +: 8];

    always_ff @(posedge clk) begin
      if (we && sel_w) mem[wa] <= wd;
      q <= mem[ra];
    end
    assign lane_q[8*g +: 8] = q;
  end

  always_ff @(posedge clk) begin
    rd_lane_q <= rd_idx[LANE_AW-1:0];
    narrow_q  <= narrow;
  end

  assign rd_data = narrow_q ? DW'(lane_q[{rd_lane_q, 3'b000} +: 8]) : lane_q;
endmodule

// File: rtl/la_capture_core.sv
module la_capture_core
  import la_pkg::*;
#(
  parameter int CH_W = 32,
  parameter int AW   = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [1:0]                     cfg_addr,
  input  logic [CFG_W-1:0]               cfg_wdata,
  input  logic                           arm,
  input  logic [CH_W-1:0]                chan_in,
  input  logic                           ext_clk,
  output logic                           busy,
  output logic                           done,
  output logic [AW+$clog2(CH_W/8):0]     cap_len,
  output logic [AW+$clog2(CH_W/8)-1:0]   trig_pos,
  input  logic                           rd_start,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [CH_W-1:0]                out_data,
  output logic                           out_last
);
  localparam int LANES   = CH_W / 8;
  localparam int LANE_AW = $clog2(LANES);
  localparam int PW      = AW + LANE_AW;
  localparam int LW      = PW + 1;
  localparam int DEPTH_W = 1 << AW;
  localparam int DEPTH_N = DEPTH_W * LANES;

  // configuration registers (host side)
  logic [CH_W-1:0] cfg_mask, cfg_val;
  mode_t           cfg_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_mask <= '0;
      cfg_val  <= '0;
      cfg_mode <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        REG_MASK:  cfg_mask <= cfg_wdata[CH_W-1:0];
        REG_VALUE: cfg_val  <= cfg_wdata[CH_W-1:0];
        REG_MODE:  cfg_mode <= mode_t'(cfg_wdata);
        default:   ;
      endcase
    end
  end

  // settings frozen at arm
  logic [CH_W-1:0] mask_r, val_r;
  mode_t           mode_r;
  logic [PW-1:0]   ptr_mask;
  logic [LW-1:0]   dep_a;
  logic [PW-1:0]   pre_lim;

  assign ptr_mask = mode_r.narrow ? {PW{1'b1}} : PW'(DEPTH_W - 1);
  assign dep_a    = cfg_mode.narrow ? LW'(DEPTH_N) : LW'(DEPTH_W);

  always_comb begin
    if (32'(cfg_mode.pre) >= 32'(dep_a)) pre_lim = PW'(dep_a - 1'b1);
    else                                 pre_lim = PW'(cfg_mode.pre);
  end

  // sample strobe and registered sample
  cap_state_t      cst;
  logic            strobe;
  logic [CH_W-1:0] chan_s, samp_q;
  logic            samp_v;

  assign busy = (cst == CAP_PRE) || (cst == CAP_POST);
  assign done = (cst == CAP_DONE);

  la_strobe #(.CH_W(CH_W), .DIV_W(DIV_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .run(busy), .ext_sel(mode_r.ext_sel),
    .div(mode_r.div), .ext_clk(ext_clk), .chan_in(chan_in),
    .strobe(strobe), .chan_out(chan_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      samp_v <= 1'b0;
    end else begin
      samp_v <= strobe;
      if (strobe) samp_q <= chan_s;
    end
  end

  logic hit;
  la_trig_match #(.CH_W(CH_W)) u_match (
    .sample(samp_q), .mask(mask_r), .value(val_r), .hit(hit)
  );

  // capture control
  logic [PW-1:0] wr_ptr, held, pre_r, pre_act, start_ptr;
  logic [LW-1:0] post_need, post_cnt;
  logic          wr_en;

  assign wr_en = samp_v && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cst       <= CAP_IDLE;
      mask_r    <= '0;
      val_r     <= '0;
      mode_r    <= '0;
      wr_ptr    <= '0;
      held      <= '0;
      pre_r     <= '0;
      pre_act   <= '0;
      start_ptr <= '0;
      post_need <= '0;
      post_cnt  <= '0;
    end else if (arm) begin
      mask_r    <= cfg_mask;
      val_r     <= cfg_mode.invert ? ~cfg_val : cfg_val;
      mode_r    <= cfg_mode;
      wr_ptr    <= '0;
      held      <= '0;
      pre_act   <= '0;
      start_ptr <= '0;
      post_cnt  <= '0;
      pre_r     <= cfg_mode.trig_en ? pre_lim : '0;
      post_need <= cfg_mode.trig_en ? dep_a - LW'(pre_lim) : dep_a;
      cst       <= cfg_mode.trig_en ? CAP_PRE : CAP_POST;
    end else if (samp_v) begin
      case (cst)
        CAP_PRE: begin
          wr_ptr <= (wr_ptr + 1'b1) & ptr_mask;
          if (hit) begin
            pre_act   <= held;
            start_ptr <= (wr_ptr - held) & ptr_mask;
            post_cnt  <= LW'(1);
            cst       <= (post_need == LW'(1)) ? CAP_DONE : CAP_POST;
          end else if (held != pre_r) begin
            held <= held + 1'b1;
          end
        end
        CAP_POST: begin
          wr_ptr   <= (wr_ptr + 1'b1) & ptr_mask;
          post_cnt <= post_cnt + 1'b1;
          if (post_cnt + 1'b1 == post_need) cst <= CAP_DONE;
        end
        default: ;
      endcase
    end
  end

  assign cap_len  = LW'(pre_act) + post_need;
  assign trig_pos = pre_act;

  // readout stream
  rd_state_t     rs;
  logic [PW-1:0] rd_ptr;
  logic [LW-1:0] rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs     <= RD_IDLE;
      rd_ptr <= '0;
      rd_cnt <= '0;
    end else if (arm) begin
      rs <= RD_IDLE;
    end else begin
      case (rs)
        RD_IDLE: if (rd_start && done) begin
          rd_ptr <= start_ptr;
          rd_cnt <= '0;
          rs     <= RD_FETCH;
        end
        RD_FETCH: rs <= RD_SHOW;
        RD_SHOW: if (out_ready) begin
          if (out_last) rs <= RD_IDLE;
          else begin
            rd_ptr <= (rd_ptr + 1'b1) & ptr_mask;
            rd_cnt <= rd_cnt + 1'b1;
            rs     <= RD_FETCH;
          end
        end
        default: rs <= RD_IDLE;
      endcase
    end
  end

  la_sample_ram #(.AW(AW), .LANES(LANES)) u_ram (
    .clk(clk), .narrow(mode_r.narrow), .we(wr_en), .wr_idx(wr_ptr),
    .wr_data(samp_q), .rd_idx(rd_ptr), .rd_data(out_data)
  );

  assign out_valid = (rs == RD_SHOW);
  assign out_last  = out_valid && (rd_cnt == cap_len - 1'b1);
endmodule

// File: rtl/la_capture_chk.sv
module la_capture_chk #(
  parameter int CH_W = 32,
  parameter int AW   = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         arm,
  input logic                         busy,
  input logic                         done,
  input logic [AW+$clog2(CH_W/8):0]   cap_len,
  input logic [AW+$clog2(CH_W/8)-1:0] trig_pos,
  input logic                         out_valid,
  input logic                         out_ready,
  input logic [CH_W-1:0]              out_data,
  input logic                         out_last
);
  // R12
  arm_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !done);

  // R11
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !arm) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R11
  valid_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> done);

  // R11
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R5
  trig_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (trig_pos < cap_len));
endmodule

bind la_capture_core la_capture_chk #(.CH_W(CH_W), .AW(AW)) u_chk (.*);

// File: tb/sim_la_capture_core.sv
module sim_la_capture_core;
  localparam int CLK_P = 10;
  localparam int AW    = 4;
  localparam int CH_W  = 32;
  localparam int DW    = 16;
  localparam int DN    = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        arm = 1'b0;
  logic [31:0] chan_in = '0;
  logic        ext_clk = 1'b0;
  logic        busy, done, out_valid, out_last;
  logic [AW+2:0] cap_len;
  logic [AW+1:0] trig_pos;
  logic        rd_start = 1'b0;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] got [64];
  int got_n;
  int last_seen;

  always #(CLK_P/2) clk = ~clk;

  la_capture_core #(.CH_W(CH_W), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .arm(arm), .chan_in(chan_in), .ext_clk(ext_clk),
    .busy(busy), .done(done), .cap_len(cap_len), .trig_pos(trig_pos),
    .rd_start(rd_start), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  function automatic logic [31:0] samp(int k);
    return 32'hA500_0000 | (32'(k) << 8) | 32'((k ^ 'h5A) & 'hFF);
  endfunction

  function automatic logic [31:0] mode_w(int trig, int inv, int nar, int ext, int div, int pre);
    return (32'(pre) << 16) | (32'(div) << 4) | (32'(ext) << 3) | (32'(nar) << 2) |
           (32'(inv) << 1) | 32'(trig);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] d);
    @(negedge clk); chan_in = d;
    repeat (3) @(negedge clk);
    ext_clk = 1'b1;
    repeat (4) @(negedge clk);
    ext_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // sends samp(k) until done, returns the number of pulses sent
  task automatic pulses_until_done(input int maxp, output int sent);
    sent = 0;
    while (!done && sent < maxp) begin
      pulse(samp(sent));
      sent++;
    end
  endtask

  task automatic read_window(input int ready_mod);
    bit fin = 1'b0;
    got_n = 0;
    last_seen = 0;
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    for (int c = 0; c < 3000 && !fin; c++) begin
      out_ready = (ready_mod == 0) || ((c % ready_mod) != 0);
      #1;
      if (out_valid && out_ready) begin
        if (got_n < 64) got[got_n] = out_data;
        if (out_last) begin fin = 1'b1; last_seen++; end
        got_n++;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
  endtask

  initial begin
    int sent;
    bit ok;
    logic [31:0] bad;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 0 && done == 0 && out_valid == 0, "R1 reset outputs", {busy, done, out_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2, R8: no trigger, external qualifier, wide
    cfg(2'd2, mode_w(0, 0, 0, 1, 0, 0));
    do_arm();
    chk(busy == 1, "R2 busy after arm", busy, 1);
    for (int k = 0; k < DW - 1; k++) pulse(samp(k));
    chk(done == 0, "R7 not done one sample early", done, 0);
    pulse(samp(DW - 1));
    chk(done == 1 && busy == 0, "R7 done after last sample", {done, busy}, 2);
    chk(cap_len == DW, "R2 length equals depth", cap_len, DW);
    chk(trig_pos == 0, "R2 trigger index zero", trig_pos, 0);
    // R11: back-pressure readout
    read_window(3);
    chk(got_n == DW, "R11 word count", got_n, DW);
    ok = 1'b1; bad = 0;
    for (int j = 0; j < DW; j++) if (got[j] !== samp(j)) begin ok = 1'b0; bad = got[j]; end
    chk(ok, "R8 one sample per edge, oldest first", bad, 0);
    chk(last_seen == 1, "R11 single last marker", last_seen, 1);
    chk(out_valid == 0, "R11 stream ends", out_valid, 0);

    // R12: arm clears done
    cfg(2'd2, mode_w(1, 0, 0, 1, 0, 0));
    do_arm();
    chk(done == 0 && busy == 1, "R12 arm clears done", {done, busy}, 1);

    // R3, R5, R7: sweep the pre-trigger count, masked bits differ from samples
    cfg(2'd0, 32'h0000_FF00);
    cfg(2'd1, 32'h5A00_00C3 | (32'd30 << 8));
    for (int pre = 0; pre < DW; pre++) begin
      cfg(2'd2, mode_w(1, 0, 0, 1, 0, pre));
      do_arm();
      pulses_until_done(80, sent);
      chk(sent == 46 - pre, "R7 done at window end", sent, 46 - pre);
      chk(trig_pos == pre, "R5 trigger index", trig_pos, pre);
      chk(cap_len == DW, "R5 window length", cap_len, DW);
      read_window(0);
      ok = (got_n == DW); bad = 0;
      for (int j = 0; j < DW; j++) if (got[j] !== samp(30 - pre + j)) begin ok = 1'b0; bad = got[j]; end
      chk(ok, "R3 masked match and R5 window content", bad, samp(30 - pre));
    end

    // R5: pre-trigger count above depth is clamped
    cfg(2'd2, mode_w(1, 0, 0, 1, 0, 200));
    do_arm();
    pulses_until_done(80, sent);
    chk(trig_pos == DW - 1, "R5 clamp of pre count", trig_pos, DW - 1);

    // R6, R12: early trigger, config change during capture ignored
    cfg(2'd1, 32'd2 << 8);
    cfg(2'd2, mode_w(1, 0, 0, 1, 0, 5));
    do_arm();
    cfg(2'd2, mode_w(0, 0, 1, 0, 0, 0));
    pulses_until_done(80, sent);
    chk(trig_pos == 2, "R6 reduced pre count", trig_pos, 2);
    chk(cap_len == 13, "R6 reduced length", cap_len, 13);
    chk(sent == 13, "R12 settings held from arm", sent, 13);
    read_window(2);
    ok = (got_n == 13); bad = 0;
    for (int j = 0; j < 13; j++) if (got[j] !== samp(j)) begin ok = 1'b0; bad = got[j]; end
    chk(ok, "R6 window content", bad, samp(0));

    // R4: inverted trigger value
    cfg(2'd1, ~(32'd30 << 8));
    cfg(2'd2, mode_w(1, 1, 0, 1, 0, 3));
    do_arm();
    pulses_until_done(80, sent);
    chk(trig_pos == 3 && sent == 43, "R4 inverted value fires", sent, 43);
    read_window(0);
    chk(got[0] === samp(27), "R4 first word", got[0], samp(27));

    // R10: narrow mode, four times the depth
    cfg(2'd2, mode_w(0, 0, 1, 1, 0, 0));
    do_arm();
    pulses_until_done(80, sent);
    chk(sent == DN, "R10 narrow depth", sent, DN);
    chk(cap_len == DN, "R10 narrow length", cap_len, DN);
    read_window(0);
    ok = (got_n == DN); bad = 0;
    for (int j = 0; j < DN; j++) if (got[j] !== {24'd0, samp(j)[7:0]}) begin ok = 1'b0; bad = got[j]; end
    chk(ok, "R10 low byte zero-extended", bad, {24'd0, samp(0)[7:0]});

    // R9: internal divider, channels ramp every cycle
    cfg(2'd2, mode_w(0, 0, 0, 0, 2, 0));
    do_arm();
    for (int c = 0; c < 400 && !done; c++) begin
      @(negedge clk); chan_in = chan_in + 1;
    end
    read_window(0);
    ok = (got_n == DW); bad = 0;
    for (int j = 1; j < DW; j++) if (got[j] - got[j-1] != 32'd3) begin ok = 1'b0; bad = got[j] - got[j-1]; end
    chk(ok, "R9 sample spacing", bad, 3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule